// File: doc/BRIEF.md
# Multiplexed Bus Strobe Sequencer

This block is the master side of an external bus on which address and data share one set of pins. An internal requester hands it one read or write at a time: an address, a direction and, for writes, a data word. The sequencer then runs one bus transaction. It drives the address under a low-active address strobe, switches the shared pins to write data or releases them for read data, and runs a low-active data strobe. It stretches each strobe phase by wait cycles. It returns the read word with a one-cycle completion pulse.

The block runs on a clock at twice the internal bus clock rate. Each clock cycle of the block is one half period of the bus clock, so strobe edges can fall in the middle of a bus clock period. A strobe phase always lasts an odd number of half periods: a whole number of full bus periods plus one high half.

The number of full periods in a phase is the largest of three values: the clock prescale value, a count programmed for that phase, and the number of periods the external device asks for on its wait line. The address phase and the data phase each have their own programmed count. While the device holds its wait line, the current phase keeps growing one full period at a time.

Top module: `mbus_strobe_seq`

## Requirements
- R1: `cmd_ready` is 1 only when the block is idle. A `cmd_valid` seen at a clock edge while idle is accepted, and `bus_as_n` is 0 from the next cycle on. `cmd_valid` and the command fields are ignored while a transaction is running.
- R2: The address-phase wait count is Wa = max(`cfg_prescale`, `cfg_as_wait`, k). k is the number of consecutive address-phase samples of `bus_wait` = 1, counted from the first. `bus_wait` = 1 requests a wait and is sampled at the end of every even-numbered cycle of the phase. `bus_as_n` stays 0 for exactly 2*Wa+1 cycles.
- R3: While `bus_as_n` is 0 and in the cycle after it rises, `bus_ad_oe` is 1 and `bus_ad_o` carries the accepted address. `bus_rw` is 1 for a read and 0 for a write from the first address cycle on.
- R4: `bus_ds_n` falls exactly one cycle after `bus_as_n` rises.
- R5: The data-phase wait count is Wd = max(`cfg_prescale`, `cfg_ds_wait`, k), with k counted the same way over the data phase. `bus_ds_n` stays 0 for exactly 2*Wd+1 cycles.
- R6: For a read, `bus_ad_oe` is 0 from the cycle in which `bus_ds_n` falls. For a write, `bus_ad_o` carries the write data with `bus_ad_oe` = 1 from that cycle through the one cycle after `bus_ds_n` rises.
- R7: `rsp_done` is 1 for exactly one cycle: the cycle after `bus_ds_n` rises. For a read, `rsp_rdata` then holds the value that `bus_ad_i` had in the last cycle with `bus_ds_n` = 0.
- R8: In the cycle after `rsp_done`, the block is idle: `bus_ad_oe` = 0, `bus_rw` = 1, both strobes are 1 and `cmd_ready` = 1. The next `bus_as_n` fall comes at least one cycle after `bus_ds_n` rises.
- R9: While `rst` is 1 and in the first cycle after it, `bus_as_n` = `bus_ds_n` = `bus_rw` = 1, `bus_ad_oe` = 0, `rsp_done` = 0 and `cmd_ready` = 1, whatever `cmd_valid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus clock rate; one cycle is one half period |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Transaction request |
| cmd_ready | output | 1 | Block is idle and takes a request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AD_W | Transaction address |
| cmd_wdata | input | AD_W | Write data |
| cfg_prescale | input | PRS_W | Clock prescale value, a lower bound on both wait counts |
| cfg_as_wait | input | WAIT_W | Programmed address-phase wait periods |
| cfg_ds_wait | input | WAIT_W | Programmed data-phase wait periods |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | AD_W | Read data captured at the data strobe rise |
| bus_ad_o | output | AD_W | Shared address/data pins, outgoing value |
| bus_ad_oe | output | 1 | Output enable for the shared pins |
| bus_ad_i | input | AD_W | Shared address/data pins, incoming value |
| bus_as_n | output | 1 | Address strobe, low active |
| bus_ds_n | output | 1 | Data strobe, low active |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_wait | input | 1 | Wait request from the device, 1 = extend the phase |

## Verification
A wrong phase state or a wait counter that is off by one shows up at the ports as a strobe edge early or late by one half or one full period. The bench compares every strobe, direction and enable pin with a model on every cycle of every transaction, so such a fault is reported in the first cycle where the edge moves. A corrupt latched command shows as a wrong word on the shared pins in the first address or write-data cycle. A wrong capture shows in `rsp_rdata` in the done cycle. A bus left driven after completion shows in the idle cycle that follows.

// File: rtl/msq_pkg.sv
package msq_pkg;

    // Transaction sequencer states; one state per strobe interval
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_AS_LOW  = 3'd1,
        ST_AS_HOLD = 3'd2,
        ST_DS_LOW  = 3'd3,
        ST_DS_HOLD = 3'd4
    } seq_state_e;

    // Which phase the shared wait counter is loaded for
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // Larger of two unsigned counts
    function automatic logic [31:0] wmax(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/msq_wait_ctr.sv
module msq_wait_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             ext_wait,
    output logic             phase_last
);

    logic [CNT_W-1:0] cnt;
    logic             hi;

    // A phase ends at the close of a high half once the programmed periods
    // are used up and the device no longer asks for more.
    assign phase_last = run && hi && (cnt == '0) && !ext_wait;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            hi  <= 1'b1;
        end else if (load) begin
            cnt <= load_val;
            hi  <= 1'b1;
        end else if (run) begin
            if (hi) begin
                if (!phase_last) begin
                    hi <= 1'b0;
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end
                end
            end else begin
                hi <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/msq_seq.sv
module msq_seq
    import msq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       phase_last,
    output seq_state_e state,
    output logic       accept,
    output logic       ctr_load,
    output phase_e     ctr_sel,
    output logic       run,
    output logic       capture
);

    seq_state_e state_nx;

    assign accept   = (state == ST_IDLE) && cmd_valid;
    assign run      = (state == ST_AS_LOW) || (state == ST_DS_LOW);
    assign ctr_load = accept || (state == ST_AS_HOLD);
    assign ctr_sel  = (state == ST_AS_HOLD) ? PH_DATA : PH_ADDR;
    assign capture  = (state == ST_DS_LOW) && phase_last;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (accept)     state_nx = ST_AS_LOW;
            ST_AS_LOW:  if (phase_last) state_nx = ST_AS_HOLD;
            ST_AS_HOLD:                 state_nx = ST_DS_LOW;
            ST_DS_LOW:  if (phase_last) state_nx = ST_DS_HOLD;
            ST_DS_HOLD:                 state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/msq_pin_drv.sv
module msq_pin_drv
    import msq_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_state_e      state,
    input  logic            accept,
    input  logic            cmd_write,
    input  logic [AD_W-1:0] cmd_addr,
    input  logic [AD_W-1:0] cmd_wdata,
    input  logic            capture,
    input  logic [AD_W-1:0] ad_in,
    output logic [AD_W-1:0] ad_out,
    output logic            ad_oe,
    output logic            as_n,
    output logic            ds_n,
    output logic            rw,
    output logic            done,
    output logic            ready,
    output logic [AD_W-1:0] rdata
);

    typedef struct packed {
        logic            wr;
        logic [AD_W-1:0] addr;
        logic [AD_W-1:0] wdata;
    } txn_t;

    txn_t            txn_q;
    logic [AD_W-1:0] rdata_q;
    logic            addr_phase;
    logic            data_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            txn_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                txn_q.wr    <= cmd_write;
                txn_q.addr  <= cmd_addr;
                txn_q.wdata <= cmd_wdata;
            end
            if (capture) begin
                rdata_q <= ad_in;
            end
        end
    end

    always_comb begin
        addr_phase = (state == ST_AS_LOW) || (state == ST_AS_HOLD);
        data_phase = (state == ST_DS_LOW) || (state == ST_DS_HOLD);
        as_n       = (state != ST_AS_LOW);
        ds_n       = (state != ST_DS_LOW);
        ad_oe      = addr_phase || (data_phase && txn_q.wr);
        if (addr_phase) begin
            ad_out = txn_q.addr;
        end else if (data_phase && txn_q.wr) begin
            ad_out = txn_q.wdata;
        end else begin
            ad_out = '0;
        end
        rw    = (state == ST_IDLE) ? 1'b1 : !txn_q.wr;
        done  = (state == ST_DS_HOLD);
        ready = (state == ST_IDLE);
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/mbus_strobe_seq.sv
module mbus_strobe_seq
    import msq_pkg::*;
#(
    parameter int AD_W   = 16,
    parameter int PRS_W  = 3,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [AD_W-1:0]   cmd_addr,
    input  logic [AD_W-1:0]   cmd_wdata,
    input  logic [PRS_W-1:0]  cfg_prescale,
    input  logic [WAIT_W-1:0] cfg_as_wait,
    input  logic [WAIT_W-1:0] cfg_ds_wait,
    output logic              rsp_done,
    output logic [AD_W-1:0]   rsp_rdata,
    output logic [AD_W-1:0]   bus_ad_o,
    output logic              bus_ad_oe,
    input  logic [AD_W-1:0]   bus_ad_i,
    output logic              bus_as_n,
    output logic              bus_ds_n,
    output logic              bus_rw,
    input  logic              bus_wait
);

    localparam int CNT_W = (PRS_W > WAIT_W) ? PRS_W : WAIT_W;

    seq_state_e       state;
    logic             accept;
    logic             ctr_load;
    phase_e           ctr_sel;
    logic             run;
    logic             capture;
    logic             phase_last;
    logic [CNT_W-1:0] load_val;
    logic [31:0]      as_floor;
    logic [31:0]      ds_floor;

    // Programmed floor for each phase: prescale value or phase count, whichever is larger
    always_comb begin
        as_floor = wmax(32'(cfg_prescale), 32'(cfg_as_wait));
        ds_floor = wmax(32'(cfg_prescale), 32'(cfg_ds_wait));
        load_val = (ctr_sel == PH_DATA) ? CNT_W'(ds_floor) : CNT_W'(as_floor);
    end

    msq_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .phase_last (phase_last),
        .state      (state),
        .accept     (accept),
        .ctr_load   (ctr_load),
        .ctr_sel    (ctr_sel),
        .run        (run),
        .capture    (capture)
    );

    msq_wait_ctr #(
        .CNT_W (CNT_W)
    ) u_wait (
        .clk        (clk),
        .rst        (rst),
        .load       (ctr_load),
        .load_val   (load_val),
        .run        (run),
        .ext_wait   (bus_wait),
        .phase_last (phase_last)
    );

    msq_pin_drv #(
        .AD_W (AD_W)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .accept    (accept),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .capture   (capture),
        .ad_in     (bus_ad_i),
        .ad_out    (bus_ad_o),
        .ad_oe     (bus_ad_oe),
        .as_n      (bus_as_n),
        .ds_n      (bus_ds_n),
        .rw        (bus_rw),
        .done      (rsp_done),
        .ready     (cmd_ready),
        .rdata     (rsp_rdata)
    );

    // R1
    as_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_as_n) |-> $past(cmd_ready && cmd_valid));

    // R3
    as_addr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_as_n |-> bus_ad_oe);

    // R4
    as_to_ds_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_as_n) |=> $fell(bus_ds_n));

    // R6
    read_float_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_ds_n && bus_rw) |-> !bus_ad_oe);

    // R7
    done_at_ds_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ds_n) |-> rsp_done);

    // R8
    idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (cmd_ready && bus_rw && !bus_ad_oe && bus_as_n && bus_ds_n));

endmodule

// File: tb/tb_mbus_strobe_seq.sv
module tb_mbus_strobe_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AD_W   = 16;
    localparam int PRS_W  = 3;
    localparam int WAIT_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic              cmd_write = 1'b0;
    logic [AD_W-1:0]   cmd_addr = '0;
    logic [AD_W-1:0]   cmd_wdata = '0;
    logic [PRS_W-1:0]  cfg_prescale = '0;
    logic [WAIT_W-1:0] cfg_as_wait = '0;
    logic [WAIT_W-1:0] cfg_ds_wait = '0;
    logic              rsp_done;
    logic [AD_W-1:0]   rsp_rdata;
    logic [AD_W-1:0]   bus_ad_o;
    logic              bus_ad_oe;
    logic [AD_W-1:0]   bus_ad_i = '0;
    logic              bus_as_n;
    logic              bus_ds_n;
    logic              bus_rw;
    logic              bus_wait = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_strobe_seq #(
        .AD_W   (AD_W),
        .PRS_W  (PRS_W),
        .WAIT_W (WAIT_W)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_write    (cmd_write),
        .cmd_addr     (cmd_addr),
        .cmd_wdata    (cmd_wdata),
        .cfg_prescale (cfg_prescale),
        .cfg_as_wait  (cfg_as_wait),
        .cfg_ds_wait  (cfg_ds_wait),
        .rsp_done     (rsp_done),
        .rsp_rdata    (rsp_rdata),
        .bus_ad_o     (bus_ad_o),
        .bus_ad_oe    (bus_ad_oe),
        .bus_ad_i     (bus_ad_i),
        .bus_as_n     (bus_as_n),
        .bus_ds_n     (bus_ds_n),
        .bus_rw       (bus_rw),
        .bus_wait     (bus_wait)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Expected {as_n, ds_n, rw, oe, done, ready} in cycle t after acceptance
    function automatic logic [5:0] exp_ctrl(input int t, input int wa, input int wd, input bit wr);
        if (t <= 2*wa)                return {1'b0, 1'b1, !wr, 1'b1, 1'b0, 1'b0};
        if (t == 2*wa + 1)            return {1'b1, 1'b1, !wr, 1'b1, 1'b0, 1'b0};
        if (t <= 2*wa + 2*wd + 2)     return {1'b1, 1'b0, !wr, wr,   1'b0, 1'b0};
        if (t == 2*wa + 2*wd + 3)     return {1'b1, 1'b1, !wr, wr,   1'b1, 1'b0};
        return {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    endfunction

    function automatic string ctrl_tag(input int t, input int wa, input int wd);
        if (t == 0)                   return "R1";
        if (t <= 2*wa)                return "R2";
        if (t == 2*wa + 1)            return "R4";
        if (t <= 2*wa + 2*wd + 2)     return "R5";
        if (t == 2*wa + 2*wd + 3)     return "R7";
        return "R8";
    endfunction

    // Called at a falling edge with the block idle; returns at the falling
    // edge of the idle cycle that ends the transaction.
    task automatic run_txn(input bit wr, input logic [AD_W-1:0] addr,
                           input logic [AD_W-1:0] wdata, input logic [AD_W-1:0] rd,
                           input int p, input int ac, input int dc,
                           input int ka, input int kd, input bit junk);
        int wa;
        int wd;
        int last;
        logic [5:0] ctrl;
        logic [5:0] ectrl;
        cfg_prescale = PRS_W'(p);
        cfg_as_wait  = WAIT_W'(ac);
        cfg_ds_wait  = WAIT_W'(dc);
        cmd_valid    = 1'b1;
        cmd_write    = wr;
        cmd_addr     = addr;
        cmd_wdata    = wdata;
        bus_ad_i     = rd;
        bus_wait     = 1'b0;
        chk("R1", "ready before request", 32'(cmd_ready), 32'd1);
        @(negedge clk);
        wa   = max3(p, ac, ka);
        wd   = max3(p, dc, kd);
        last = 2*wa + 2*wd + 4;
        for (int t = 0; t <= last; t++) begin
            ctrl  = {bus_as_n, bus_ds_n, bus_rw, bus_ad_oe, rsp_done, cmd_ready};
            ectrl = exp_ctrl(t, wa, wd, wr);
            chk(ctrl_tag(t, wa, wd), $sformatf("ctrl t=%0d", t), 32'(ctrl), 32'(ectrl));
            if (t <= 2*wa + 1) begin
                chk("R3", $sformatf("address t=%0d", t), 32'(bus_ad_o), 32'(addr));
            end else if (wr && t <= 2*wa + 2*wd + 3) begin
                chk("R6", $sformatf("write data t=%0d", t), 32'(bus_ad_o), 32'(wdata));
            end
            if (!wr && t == 2*wa + 2*wd + 3) begin
                chk("R7", "read data", 32'(rsp_rdata), 32'(rd));
            end
            // inputs for this cycle, sampled at its closing edge
            if (junk && t < 2*wa + 2) begin
                cmd_valid = 1'b1;
                cmd_write = !wr;
                cmd_addr  = ~addr;
                cmd_wdata = ~wdata;
            end else begin
                cmd_valid = 1'b0;
            end
            if (t <= 2*wa) begin
                bus_wait = ((t / 2) < ka);
            end else if (t >= 2*wa + 2 && t <= 2*wa + 2*wd + 2) begin
                bus_wait = (((t - 2*wa - 2) / 2) < kd);
            end else begin
                bus_wait = 1'b0;
            end
            if (t < last) begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog got=busy exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst       = 1'b1;
        cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset holds the bus idle even with a pending request
        chk("R9", "reset ctrl", 32'({bus_as_n, bus_ds_n, bus_rw, bus_ad_oe, rsp_done, cmd_ready}),
            32'(6'b111001));
        cmd_valid = 1'b0;
        rst       = 1'b0;
        @(negedge clk);
        chk("R9", "ctrl after reset", 32'({bus_as_n, bus_ds_n, bus_rw, bus_ad_oe, rsp_done, cmd_ready}),
            32'(6'b111001));

        // Directed corners
        run_txn(1'b0, 16'h1234, 16'h0000, 16'hBEEF, 0, 0, 0, 0, 0, 1'b0);   // no waits
        run_txn(1'b1, 16'hA5A5, 16'h5A5A, 16'h0000, 2, 1, 0, 0, 0, 1'b0);   // prescale dominates
        run_txn(1'b0, 16'h0F0F, 16'h0000, 16'hC3C3, 1, 3, 1, 0, 0, 1'b0);   // programmed counts dominate
        run_txn(1'b1, 16'h8001, 16'h7FFE, 16'h0000, 0, 1, 0, 3, 2, 1'b1);   // device waits dominate, busy request ignored
        run_txn(1'b0, 16'hFFFF, 16'h0000, 16'h0001, 7, 15, 15, 2, 16, 1'b1); // largest counts
        run_txn(1'b1, 16'h0000, 16'hFFFF, 16'h0000, 0, 0, 0, 0, 0, 1'b0);   // back-to-back write

        // Constrained random
        for (int i = 0; i < 60; i++) begin
            run_txn(1'($urandom % 2), 16'($urandom), 16'($urandom), 16'($urandom),
                    int'($urandom % 3), int'($urandom % 4), int'($urandom % 4),
                    int'($urandom % 5), int'($urandom % 5), 1'($urandom % 2));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule